// File: doc/BRIEF.md
# Settable Binary Time-of-Day Counter

This block keeps a 12-hour time of day with a half-day flag from a single 100 kHz clock enable. A five-stage decimal prescaler turns the enable into one-second steps. The steps then ripple through six fields: seconds units, seconds tens, minutes units, minutes tens, hours 0 to 11, and a post-meridiem bit. The whole time is shown as one 19-bit word in which each field is plain binary. Every stage runs on the one clock through synchronous enables, so the block has no derived clocks.

To set the time, an operator raises the hold input. The time then stops, except for the advance picked by a 2-bit rate code. That advance enters the last two prescaler stages, which sit at the 100 Hz point of the chain, so one prescaler count from an input pulse is one hundredth of a displayed second. The code picks one of three pulse sources for that point: the raw input enable, which gives 1000 times normal speed; the 1 kHz tap, which gives 10 times normal speed; or the 100 Hz tap, which gives normal speed. When hold drops, the time stays frozen until a start strobe arrives. The strobe clears the sub-second prescaler, so the first displayed second is a full second long.

Further outputs are the prescaler taps, a one-cycle pulse for each second, a second-phase level that is high for the last tenth of each second, and a 1 kHz tone gated by that level.

Top module: `tod_counter`

## Requirements
- R1: While rst_n is low, time_o is all zero (00:00:00, AM) and sec_tick_o, sec_level_o and tone_o are low.
- R2: In normal running, time_o advances by exactly one second after every DEC_RATIO^5 clock cycles with ce_i high (100000 by default). Cycles with ce_i low make no progress.
- R3: time_o packs the fields as follows: [3:0] seconds units 0..9, [6:4] seconds tens 0..5, [10:7] minutes units 0..9, [13:11] minutes tens 0..5, [17:14] hours 0..11, [18] PM. Each field carries into the next when it wraps.
- R4: When hours wrap from 11 to 0, the PM bit toggles and all other fields read zero.
- R5: While hold_i is high, the only pulses fed into the 100 Hz stage are those chosen by set_rate_i. Code 0 feeds none, so the time is frozen. Code 1 feeds every ce_i (1000x). Code 2 feeds the 1 kHz tap (10x). Code 3 feeds the 100 Hz tap (1x).
- R6: After hold_i falls, time_o stays frozen whatever ce_i does, until a start strobe is seen.
- R7: start_i passes through two synchronising flops, and a rising edge is acted on only while the counter is waiting. The third clock edge after start_i rises clears the whole prescaler and resumes normal running. The next second then comes exactly DEC_RATIO^5 ce_i pulses after that edge.
- R8: sec_tick_o is high for exactly the one cycle that follows each one-second advance of time_o.
- R9: sec_level_o is high while the last prescaler stage holds its final count, which is the last tenth of each second.
- R10: tone_o is sec_level_o ANDed with a 1 kHz square wave. The square wave is high while the second prescaler stage is below DEC_RATIO/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | 100 kHz count enable |
| hold_i | input | 1 | Stop the time for presetting |
| set_rate_i | input | 2 | Set-mode advance rate code |
| start_i | input | 1 | Asynchronous start strobe |
| time_o | output | 19 | Packed time-of-day word |
| taps_o | output | 6 | One-cycle prescaler taps: [0] 10 kHz, [1] 1 kHz, [2] 100 Hz, [3] 50 Hz, [4] 10 Hz, [5] 1 Hz |
| sec_tick_o | output | 1 | One-cycle pulse after each second |
| sec_level_o | output | 1 | High during the last tenth of each second |
| tone_o | output | 1 | 1 kHz tone burst once per second |

## Verification
The bench builds the block with DEC_RATIO set to 2. One second then takes 32 enables at normal speed and only 4 in the 1000x set mode. The 100 Hz-level stages stay distinct from the input-side stages, so each of the three set rates still gives a different advance. With this ratio, a run of 1000x setting covers the full twelve hours within the cycle budget, which tests the hours wrap and the PM toggle. It also tests exact start-to-first-second timing, second by second.

// File: rtl/tod_pkg.sv
package tod_pkg;

  // Set-rate code; also used as the feed selector of the 100 Hz stage.
  typedef enum logic [1:0] {
    RATE_OFF   = 2'd0,
    RATE_X1000 = 2'd1,
    RATE_X10   = 2'd2,
    RATE_X1    = 2'd3
  } set_rate_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SET   = 2'd1,
    ST_ARMED = 2'd2
  } ctl_state_e;

  localparam int PRE_STAGES = 5;   // decades from the input rate down to 1 Hz
  localparam int FEED_STAGE = 3;   // first stage fed at the 100 Hz level
  localparam int FIELDS     = 6;
  localparam int WORD_W     = 19;
  localparam int TAP_W      = 6;

  function automatic int field_mod(input int idx);
    case (idx)
      0: return 10;
      1: return 6;
      2: return 10;
      3: return 6;
      4: return 12;
      default: return 2;
    endcase
  endfunction

  function automatic int field_width(input int idx);
    case (idx)
      0: return 4;
      1: return 3;
      2: return 4;
      3: return 3;
      4: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int field_lsb(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += field_width(k);
    return acc;
  endfunction

endpackage

// File: rtl/tod_modcnt.sv
module tod_modcnt #(
  parameter int MOD = 10,
  parameter int QW  = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [QW-1:0] q_o,
  output logic          wrap_o
);

  logic [QW-1:0] cnt_q;
  logic [QW-1:0] cnt_d;
  logic          at_top;

  assign at_top = (cnt_q == QW'(MOD - 1));
  assign wrap_o = en_i & at_top;
  assign q_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = at_top ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler
  import tod_pkg::*;
#(
  parameter int DEC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic             clr_i,
  input  set_rate_e        feed_sel_i,
  output logic [TAP_W-1:0] taps_o,
  output logic             sec_en_o,
  output logic             sq1k_o,
  output logic             last_tenth_o
);

  localparam int DW = (DEC > 1) ? $clog2(DEC) : 1;

  logic feed;

  for (genvar i = 0; i < PRE_STAGES; i++) begin : g_stage
    logic          en_s;
    logic          wrap_s;
    logic [DW-1:0] q_s;

    if (i == 0) begin : g_in
      assign en_s = ce_i;
    end else if (i == FEED_STAGE) begin : g_feed
      assign en_s = feed;
    end else begin : g_chain
      assign en_s = g_stage[i-1].wrap_s;
    end

    tod_modcnt #(.MOD(DEC), .QW(DW)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_i),
      .en_i   (en_s),
      .q_o    (q_s),
      .wrap_o (wrap_s)
    );
  end

  // Pulse source of the 100 Hz-level stage
  always_comb begin
    case (feed_sel_i)
      RATE_X1000: feed = ce_i;
      RATE_X10:   feed = g_stage[1].wrap_s;
      RATE_X1:    feed = g_stage[2].wrap_s;
      default:    feed = 1'b0;
    endcase
  end

  assign taps_o[0] = g_stage[0].wrap_s;
  assign taps_o[1] = g_stage[1].wrap_s;
  assign taps_o[2] = g_stage[2].wrap_s;
  assign taps_o[3] = feed & g_stage[FEED_STAGE].q_s[0];
  assign taps_o[4] = g_stage[3].wrap_s;
  assign taps_o[5] = g_stage[4].wrap_s;

  assign sec_en_o     = g_stage[PRE_STAGES-1].wrap_s;
  assign sq1k_o       = (g_stage[1].q_s < DW'(DEC / 2));
  assign last_tenth_o = (g_stage[PRE_STAGES-1].q_s == DW'(DEC - 1));

  logic unused_stage_bits;
  assign unused_stage_bits = ^{g_stage[0].q_s, g_stage[2].q_s, g_stage[3].q_s};

endmodule

// File: rtl/tod_timekeep.sv
module tod_timekeep
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_en_i,
  output logic [WORD_W-1:0] word_o
);

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    localparam int M = field_mod(i);
    localparam int W = field_width(i);
    localparam int L = field_lsb(i);

    logic         en_s;
    logic         carry_s;
    logic [W-1:0] q_s;

    if (i == 0) begin : g_first
      assign en_s = sec_en_i;
    end else begin : g_next
      assign en_s = g_field[i-1].carry_s;
    end

    tod_modcnt #(.MOD(M), .QW(W)) u_field (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (1'b0),
      .en_i   (en_s),
      .q_o    (q_s),
      .wrap_o (carry_s)
    );

    assign word_o[L +: W] = q_s;
  end

  logic unused_day_carry;
  assign unused_day_carry = g_field[FIELDS-1].carry_s;

endmodule

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold_i,
  input  set_rate_e rate_i,
  input  logic      start_i,
  output set_rate_e feed_sel_o,
  output logic      clr_o
);

  ctl_state_e state_q;
  ctl_state_e state_d;
  logic [2:0] sync_q;
  logic [2:0] sync_d;
  logic       start_edge;

  assign sync_d     = {sync_q[1:0], start_i};
  assign start_edge = sync_q[1] & ~sync_q[2];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:   if (hold_i) state_d = ST_SET;
      ST_SET:   if (!hold_i) state_d = ST_ARMED;
      ST_ARMED: begin
        if (hold_i) begin
          state_d = ST_SET;
        end else if (start_edge) begin
          state_d = ST_RUN;
        end
      end
      default:  state_d = ST_RUN;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_RUN:  feed_sel_o = RATE_X1;
      ST_SET:  feed_sel_o = rate_i;
      default: feed_sel_o = RATE_OFF;
    endcase
  end

  assign clr_o = (state_q == ST_ARMED) & ~hold_i & start_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      sync_q  <= '0;
    end else begin
      state_q <= state_d;
      sync_q  <= sync_d;
    end
  end

endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int DEC_RATIO = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_i,
  input  logic        hold_i,
  input  logic [1:0]  set_rate_i,
  input  logic        start_i,
  output logic [18:0] time_o,
  output logic [5:0]  taps_o,
  output logic        sec_tick_o,
  output logic        sec_level_o,
  output logic        tone_o
);

  set_rate_e feed_sel;
  logic      pre_clr;
  logic      sec_en;
  logic      sq1k;
  logic      last_tenth;
  logic      tick_q;
  logic      tick_d;

  tod_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (hold_i),
    .rate_i     (set_rate_e'(set_rate_i)),
    .start_i    (start_i),
    .feed_sel_o (feed_sel),
    .clr_o      (pre_clr)
  );

  tod_prescaler #(.DEC(DEC_RATIO)) u_pre (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_i         (ce_i),
    .clr_i        (pre_clr),
    .feed_sel_i   (feed_sel),
    .taps_o       (taps_o),
    .sec_en_o     (sec_en),
    .sq1k_o       (sq1k),
    .last_tenth_o (last_tenth)
  );

  tod_timekeep u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_en_i (sec_en),
    .word_o   (time_o)
  );

  assign tick_d = sec_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign sec_tick_o  = tick_q;
  assign sec_level_o = last_tenth;
  assign tone_o      = last_tenth & sq1k;

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hold_i,
  input logic [1:0]  set_rate_i,
  input logic [18:0] time_o,
  input logic        sec_tick_o,
  input logic        sec_level_o,
  input logic        tone_o
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
    end
  end

  // R3: every field stays inside its modulus
  assert_field_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (time_o[3:0] <= 4'd9) && (time_o[6:4] <= 3'd5) && (time_o[10:7] <= 4'd9) &&
    (time_o[13:11] <= 3'd5) && (time_o[17:14] <= 4'd11));

  // R5: hold with code 0 freezes the time
  assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && hold_i && $past(hold_i) && (set_rate_i == 2'd0)) |=> $stable(time_o));

  // R8: a tick only follows an actual change of the seconds units
  assert_tick_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && sec_tick_o) |-> !$stable(time_o[3:0]));

  // R2: seconds units step by one or wrap 9 to 0
  assert_units_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$stable(time_o[3:0])) |->
      ((time_o[3:0] == $past(time_o[3:0]) + 4'd1) ||
       ((time_o[3:0] == 4'd0) && ($past(time_o[3:0]) == 4'd9))));

  // R4: PM flips only at 00:00:00 of the other half-day
  assert_pm_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$stable(time_o[18])) |-> (time_o[17:0] == 18'd0));

  // R10: the tone sounds only within the second-phase window
  assert_tone_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tone_o |-> sec_level_o);

endmodule

bind tod_counter tod_counter_chk u_tod_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_i      (hold_i),
  .set_rate_i  (set_rate_i),
  .time_o      (time_o),
  .sec_tick_o  (sec_tick_o),
  .sec_level_o (sec_level_o),
  .tone_o      (tone_o)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;

  localparam int CLK_PERIOD = 10;
  localparam int D  = 2;
  localparam int D2 = D * D;
  localparam int D3 = D2 * D;
  localparam int T  = D3 * D2;
  localparam int WATCHDOG = 199000;

  localparam int M_RUN = 0;
  localparam int M_SET = 1;
  localparam int M_ARMED = 2;

  logic        clk;
  logic        rst_n;
  logic        ce_i;
  logic        hold_i;
  logic [1:0]  set_rate_i;
  logic        start_i;
  logic [18:0] time_o;
  logic [5:0]  taps_o;
  logic        sec_tick_o;
  logic        sec_level_o;
  logic        tone_o;

  tod_counter #(.DEC_RATIO(D)) i_tod_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_i        (ce_i),
    .hold_i      (hold_i),
    .set_rate_i  (set_rate_i),
    .start_i     (start_i),
    .time_o      (time_o),
    .taps_o      (taps_o),
    .sec_tick_o  (sec_tick_o),
    .sec_level_o (sec_level_o),
    .tone_o      (tone_o)
  );

  int  vectors;
  int  fails;
  int  n_low;
  int  hi;
  int  mode;
  bit  exp_tick;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // R3 layout of the expected word
  function automatic logic [18:0] pack_time(input int secs);
    int r;
    logic [18:0] w;
    r = secs % 86400;
    w = '0;
    w[18]    = (r >= 43200);
    r        = r % 43200;
    w[17:14] = 4'(r / 3600);
    w[13:11] = 3'((r / 600) % 6);
    w[10:7]  = 4'((r / 60) % 10);
    w[6:4]   = 3'((r % 60) / 10);
    w[3:0]   = 4'(r % 10);
    return w;
  endfunction

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual cycles %0d, expected fewer", WATCHDOG);
    finish_run();
  end

  task automatic model_edge(input bit ce_v);
    bit feed;
    int old_s;
    old_s = hi / D2;
    feed  = 1'b0;
    if (mode == M_RUN) begin
      feed = ce_v && (n_low == D3 - 1);
    end else if (mode == M_SET) begin
      case (set_rate_i)
        2'd1: feed = ce_v;
        2'd2: feed = ce_v && ((n_low % D2) == D2 - 1);
        2'd3: feed = ce_v && (n_low == D3 - 1);
        default: feed = 1'b0;
      endcase
    end
    if (ce_v) n_low = (n_low + 1) % D3;
    if (feed) hi++;
    exp_tick = ((hi / D2) != old_s);
  endtask

  task automatic check_all(input string req);
    logic [18:0] e_time;
    bit e_lvl;
    bit e_tone;
    bit bad;
    e_time = pack_time(hi / D2);
    e_lvl  = (((hi / D) % D) == D - 1);
    e_tone = e_lvl && (((n_low / D) % D) < D / 2);
    bad = 1'b0;
    vectors++;
    if (time_o !== e_time) begin
      $display("FAIL %s time: actual %h expected %h", req, time_o, e_time);
      bad = 1'b1;
    end
    if (sec_tick_o !== exp_tick) begin
      $display("FAIL R8 tick: actual %b expected %b", sec_tick_o, exp_tick);
      bad = 1'b1;
    end
    if (sec_level_o !== e_lvl) begin
      $display("FAIL R9 level: actual %b expected %b", sec_level_o, e_lvl);
      bad = 1'b1;
    end
    if (tone_o !== e_tone) begin
      $display("FAIL R10 tone: actual %b expected %b", tone_o, e_tone);
      bad = 1'b1;
    end
    if (bad) fails++;
  endtask

  task automatic step(input bit ce_v, input string req);
    ce_i = ce_v;
    @(posedge clk);
    model_edge(ce_v);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic set_hold(input bit h);
    hold_i = h;
    step(1'b0, "R5");
    mode = h ? M_SET : M_ARMED;
  endtask

  task automatic set_rate(input logic [1:0] r);
    set_rate_i = r;
    step(1'b0, "R5");
  endtask

  task automatic direct(input bit cond, input string req, input logic [18:0] act,
                        input logic [18:0] exp);
    vectors++;
    if (!cond) begin
      fails++;
      $display("FAIL %s direct: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    logic [18:0] frozen;
    int s0;
    void'($urandom(32'd1974));
    vectors = 0; fails = 0;
    n_low = 0; hi = 0; mode = M_RUN; exp_tick = 1'b0;
    rst_n = 1'b0; ce_i = 1'b0; hold_i = 1'b0; set_rate_i = 2'd0; start_i = 1'b0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      ce_i = 1'b1;
      check_all("R1");
    end
    ce_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3: normal running with random enable gaps
    for (int k = 0; k < 2500; k++) step(($urandom % 4) != 0, "R2/R3");

    // R5: hold with code 0 freezes regardless of enables
    set_hold(1'b1);
    frozen = time_o;
    for (int k = 0; k < 300; k++) step(($urandom % 4) != 0, "R5");
    direct(time_o === frozen, "R5", time_o, frozen);

    // R5: random set-rate segments
    for (int seg = 0; seg < 20; seg++) begin
      set_rate(2'($urandom % 4));
      for (int k = 0; k < 150; k++) step(($urandom % 3) != 0, "R5");
    end
    set_rate(2'd0);

    // R6: released but not started
    set_hold(1'b0);
    frozen = time_o;
    for (int k = 0; k < 300; k++) step(($urandom % 4) != 0, "R6");
    direct(time_o === frozen, "R6", time_o, frozen);

    // R7: synchronised start clears the prescaler
    start_i = 1'b1;
    step(1'b0, "R7");
    step(1'b0, "R7");
    ce_i = 1'b0;
    @(posedge clk);
    n_low = 0;
    hi = hi - (hi % D2);
    exp_tick = 1'b0;
    mode = M_RUN;
    @(negedge clk);
    check_all("R7");
    start_i = 1'b0;
    s0 = hi / D2;
    for (int k = 0; k < T - 1; k++) step(1'b1, "R7");
    direct(time_o === pack_time(s0), "R7", time_o, pack_time(s0));
    step(1'b1, "R7");
    direct(time_o === pack_time(s0 + 1), "R7", time_o, pack_time(s0 + 1));
    direct(sec_tick_o === 1'b1, "R8", 19'(sec_tick_o), 19'd1);
    step(1'b1, "R8");
    direct(sec_tick_o === 1'b0, "R8", 19'(sec_tick_o), 19'd0);

    // R2: running again after start
    for (int k = 0; k < 1000; k++) step(($urandom % 4) != 0, "R2");

    // R4: 1000x set through the half-day rollover
    set_hold(1'b1);
    set_rate(2'd1);
    while ((hi / D2) < 43205) step(1'b1, "R4");
    direct(time_o[18] === 1'b1, "R4", time_o, pack_time(hi / D2));

    finish_run();
  end

endmodule